// File: doc/BRIEF.md
# Remote Terminal Status Word Composer

This block assembles the 16-bit status word that a serial-bus remote terminal sends back after each valid command addressed to it. The word carries the terminal's own strapped 5-bit address in its upper field, together with a set of condition bits. Host discretes set those bits: service request, acceptance of dynamic bus control, terminal flag, busy, subsystem flag and illegal command. The block also decides whether the terminal may answer at all, and whether data words that would normally follow the status must be withheld. Manchester coding and bus timing are handled elsewhere. The word is handed to that logic over a valid/ready response stream.

The address straps carry an odd-parity line. When parity fails, an active-low error pin falls, and the terminal stays silent to every command for as long as the fault lasts. A command arrives as a one-beat valid/ready transfer, with a flag that marks it as broadcast. A broadcast command gets no status reply. It does set the broadcast-received bit of the next status word that is sent.

Back-pressure follows one rule. While a status word is waiting (`rsp_valid` high and `rsp_ready` low), the word and the suppress flag hold steady and `cmd_ready` stays low. A command can only be accepted once the pending word has been taken.

Top module: `rt_status_composer`

## Requirements
- R1: After reset `rsp_valid` is 0, `cmd_ready` is 1 and `addr_err_n` is 1.
- R2: One clock after the straps settle, `addr_err_n` is 0 exactly when the XOR of `addr_strap[4:0]` and `addr_par` is 0 (odd parity over six bits is required).
- R3: A command accepted (`cmd_valid` and `cmd_ready` high at a clock edge) with good parity and `cmd_bcast`=0 makes `rsp_valid` 1 after that edge, with `status_word[15:11]` equal to `addr_strap`.
- R4: A command accepted while parity is bad is consumed and produces no response: `rsp_valid` stays 0.
- R5: The discretes are sampled at the accepting edge: bit 8 = `svc_req`, bit 3 = `busy`, bit 2 = `ss_flag`, bit 1 = `dyn_bus_ok`, bit 0 = `term_flag`.
- R6: `illegal_cmd` sampled high sets message error bit 10 and drives `data_sup` high for that response; otherwise both are 0.
- R7: Bit 9 and bits 7..5 of the status word are always 0.
- R8: An accepted broadcast command with good parity produces no response. The next status word sent has bit 4 set, and later words have it clear until another broadcast arrives. A bad-parity command leaves a pending broadcast mark in place.
- R9: While `rsp_valid` is high, `cmd_ready` is 0. `rsp_valid`, `status_word` and `data_sup` hold until a clock edge with `rsp_ready` high, after which `rsp_valid` is 0.
- R10: Discrete changes after the accepting edge do not alter the word already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 5 | Strapped terminal address |
| addr_par | input | 1 | Strapped odd-parity bit for the address |
| svc_req | input | 1 | Host service request discrete |
| dyn_bus_ok | input | 1 | Host accepts dynamic bus control |
| term_flag | input | 1 | Host terminal flag discrete |
| busy | input | 1 | Host busy discrete |
| ss_flag | input | 1 | Host subsystem fault discrete |
| illegal_cmd | input | 1 | Host marks current command illegal |
| cmd_valid | input | 1 | Valid command offered |
| cmd_bcast | input | 1 | Offered command is broadcast |
| cmd_ready | output | 1 | Command can be accepted |
| rsp_valid | output | 1 | Status word ready to send (respond enable) |
| rsp_ready | input | 1 | Encoder takes the status word |
| status_word | output | 16 | Composed status word |
| data_sup | output | 1 | Suppress data words after this status |
| addr_err_n | output | 1 | Low when address parity fails |

## Verification
A response appears one clock after the accepting edge. The address error pin lags a strap change by one clock. `rsp_valid` drops one clock after the edge on which `rsp_ready` is high. The bench drives on falling edges and samples on the next falling edge after each of these due edges. While a response is held back, the bench changes the discretes and checks the word and suppress flag on every cycle of the hold.

// File: rtl/rtsc_pkg.sv
package rtsc_pkg;
  typedef struct packed {
    logic svc_req;
    logic dyn_bus_ok;
    logic term_flag;
    logic busy;
    logic ss_flag;
    logic illegal;
  } disc_t;

  localparam int LOW_W     = 11;
  localparam int BIT_ME    = 10;
  localparam int BIT_INSTR = 9;
  localparam int BIT_SR    = 8;
  localparam int BIT_RSV_H = 7;
  localparam int BIT_RSV_L = 5;
  localparam int BIT_BCR   = 4;
  localparam int BIT_BUSY  = 3;
  localparam int BIT_SSF   = 2;
  localparam int BIT_DBC   = 1;
  localparam int BIT_TF    = 0;
endpackage

// File: rtl/rtsc_addr_check.sv
module rtsc_addr_check #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic              addr_par,
  output logic              par_ok,
  output logic              addr_err_n
);
  // Odd parity: the six bits together must hold an odd count of ones.
  assign par_ok = ^{addr_strap, addr_par};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_err_n <= 1'b1;
    else        addr_err_n <= par_ok;
  end
endmodule

// File: rtl/rtsc_bcast_track.sv
module rtsc_bcast_track (
  input  logic clk,
  input  logic rst_n,
  input  logic bc_set,
  input  logic bc_take,
  output logic bc_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bc_pend <= 1'b0;
    else if (bc_set)  bc_pend <= 1'b1;
    else if (bc_take) bc_pend <= 1'b0;
  end
endmodule

// File: rtl/rtsc_field_latch.sv
module rtsc_field_latch #(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap,
  input  logic [ADDR_W-1:0]     addr_in,
  input  rtsc_pkg::disc_t       disc_in,
  input  logic                  bc_in,
  output logic [ADDR_W-1:0]     addr_q,
  output rtsc_pkg::disc_t       disc_q,
  output logic                  bc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      disc_q <= '0;
      bc_q   <= 1'b0;
    end else if (cap) begin
      addr_q <= addr_in;
      disc_q <= disc_in;
      bc_q   <= bc_in;
    end
  end
endmodule

// File: rtl/rtsc_word_pack.sv
module rtsc_word_pack #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = ADDR_W + rtsc_pkg::LOW_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  rtsc_pkg::disc_t   disc,
  input  logic              bc,
  output logic [WORD_W-1:0] word
);
  import rtsc_pkg::*;
  always_comb begin
    word = '0;
    word[WORD_W-1 -: ADDR_W] = addr;
    word[BIT_ME]    = disc.illegal;
    word[BIT_INSTR] = 1'b0;
    word[BIT_SR]    = disc.svc_req;
    word[BIT_RSV_H:BIT_RSV_L] = '0;
    word[BIT_BCR]   = bc;
    word[BIT_BUSY]  = disc.busy;
    word[BIT_SSF]   = disc.ss_flag;
    word[BIT_DBC]   = disc.dyn_bus_ok;
    word[BIT_TF]    = disc.term_flag;
  end
endmodule

// File: rtl/rt_status_composer.sv
module rt_status_composer #(
  parameter int ADDR_W = 5,
  localparam int WORD_W = ADDR_W + rtsc_pkg::LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic              addr_par,
  input  logic              svc_req,
  input  logic              dyn_bus_ok,
  input  logic              term_flag,
  input  logic              busy,
  input  logic              ss_flag,
  input  logic              illegal_cmd,
  input  logic              cmd_valid,
  input  logic              cmd_bcast,
  output logic              cmd_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] status_word,
  output logic              data_sup,
  output logic              addr_err_n
);
  import rtsc_pkg::*;

  logic par_ok, accept, respond, bc_set, bc_pend, bc_q;
  logic [ADDR_W-1:0] addr_q;
  disc_t disc_live, disc_q;

  assign disc_live = '{svc_req: svc_req, dyn_bus_ok: dyn_bus_ok,
                       term_flag: term_flag, busy: busy,
                       ss_flag: ss_flag, illegal: illegal_cmd};

  assign cmd_ready = ~rsp_valid;
  assign accept    = cmd_valid & cmd_ready;
  assign respond   = accept & par_ok & ~cmd_bcast;
  assign bc_set    = accept & par_ok & cmd_bcast;

  rtsc_addr_check #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .addr_par(addr_par),
    .par_ok(par_ok), .addr_err_n(addr_err_n));

  rtsc_bcast_track u_bc (
    .clk(clk), .rst_n(rst_n), .bc_set(bc_set), .bc_take(respond),
    .bc_pend(bc_pend));

  rtsc_field_latch #(.ADDR_W(ADDR_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .cap(respond), .addr_in(addr_strap),
    .disc_in(disc_live), .bc_in(bc_pend), .addr_q(addr_q),
    .disc_q(disc_q), .bc_q(bc_q));

  rtsc_word_pack #(.ADDR_W(ADDR_W)) u_pack (
    .addr(addr_q), .disc(disc_q), .bc(bc_q), .word(status_word));

  assign data_sup = rsp_valid & disc_q.illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_valid <= 1'b0;
    else if (respond)   rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end
endmodule

// File: rtl/rtsc_checker.sv
module rtsc_checker #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = ADDR_W + 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_strap,
  input logic              addr_par,
  input logic              cmd_valid,
  input logic              cmd_bcast,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] status_word,
  input logic              data_sup,
  input logic              addr_err_n
);
  logic good;
  assign good = ^{addr_strap, addr_par};

  assert_err_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> addr_err_n == $past(good));

  assert_silent_bad_par_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !good) |=> !rsp_valid);

  assert_addr_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && good && !cmd_bcast) |=>
      (rsp_valid && status_word[WORD_W-1 -: ADDR_W] == $past(addr_strap)));

  assert_sup_me_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> data_sup == status_word[10]);

  assert_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (status_word[9] == 1'b0 && status_word[7:5] == 3'b000));

  assert_bcast_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_bcast) |=> !rsp_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(status_word) && $stable(data_sup)));

  assert_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
endmodule

bind rt_status_composer rtsc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .addr_par(addr_par),
  .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .status_word(status_word),
  .data_sup(data_sup), .addr_err_n(addr_err_n));

// File: tb/rt_status_composer_bench.sv
module rt_status_composer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr_strap = '0;
  logic addr_par = 1'b1;
  logic svc_req = 0, dyn_bus_ok = 0, term_flag = 0, busy = 0, ss_flag = 0, illegal_cmd = 0;
  logic cmd_valid = 0, cmd_bcast = 0, rsp_ready = 0;
  logic cmd_ready, rsp_valid, data_sup, addr_err_n;
  logic [15:0] status_word;

  int nchk = 0, nerr = 0;
  bit bc_pend = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_status_composer u_rt_status_composer (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .addr_par(addr_par),
    .svc_req(svc_req), .dyn_bus_ok(dyn_bus_ok), .term_flag(term_flag),
    .busy(busy), .ss_flag(ss_flag), .illegal_cmd(illegal_cmd),
    .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .status_word(status_word),
    .data_sup(data_sup), .addr_err_n(addr_err_n));

  // disc bits: [4]=svc_req [3]=busy [2]=ss_flag [1]=dyn_bus_ok [0]=term_flag
  function automatic logic [15:0] exp_word(input logic [4:0] a, input logic me,
                                           input logic bc, input logic [4:0] d);
    return {a, me, 1'b0, d[4], 3'b000, bc, d[3], d[2], d[1], d[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_disc(input logic [4:0] d);
    svc_req = d[4]; busy = d[3]; ss_flag = d[2]; dyn_bus_ok = d[1]; term_flag = d[0];
  endtask

  task automatic do_cmd(input logic [4:0] a, input bit par_good, input bit bc,
                        input bit ill, input logic [4:0] d, input int hold);
    logic [15:0] w;
    bit answer;
    @(negedge clk);
    addr_strap = a;
    addr_par = par_good ? ~(^a) : (^a);
    set_disc(d); illegal_cmd = ill; cmd_bcast = bc;
    @(negedge clk);
    chk("R2 addr_err_n", {31'b0, addr_err_n}, {31'b0, par_good});
    chk("R9 cmd_ready idle", {31'b0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    answer = par_good && !bc;
    if (answer) begin
      w = exp_word(a, ill, bc_pend, d);
      chk("R3 rsp_valid", {31'b0, rsp_valid}, 32'd1);
      chk("R3 R5 R8 status_word", {16'b0, status_word}, {16'b0, w});
      chk("R6 data_sup", {31'b0, data_sup}, {31'b0, ill});
      chk("R7 zero bits", {28'b0, status_word[9], status_word[7:5]}, 32'd0);
      chk("R9 cmd_ready busy", {31'b0, cmd_ready}, 32'd0);
      bc_pend = 0;
      for (int i = 0; i < hold; i++) begin
        set_disc($urandom_range(0, 31)); illegal_cmd = $urandom_range(0, 1);
        @(negedge clk);
        chk("R9 R10 held word", {15'b0, data_sup, status_word}, {15'b0, ill, w});
        chk("R9 held valid", {31'b0, rsp_valid}, 32'd1);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R9 release", {31'b0, rsp_valid}, 32'd0);
    end else begin
      chk(bc ? "R8 broadcast silent" : "R4 bad parity silent", {31'b0, rsp_valid}, 32'd0);
      if (bc && par_good) bc_pend = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1553_0042));
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 cmd_ready", {31'b0, cmd_ready}, 32'd1);
    chk("R1 addr_err_n", {31'b0, addr_err_n}, 32'd1);
    rst_n = 1'b1;

    // Directed corners
    do_cmd(5'd0,  1, 0, 0, 5'b00000, 0);
    do_cmd(5'd31, 1, 0, 1, 5'b11111, 2);
    do_cmd(5'd9,  0, 0, 0, 5'b10101, 0);   // R4
    do_cmd(5'd9,  1, 1, 0, 5'b00000, 0);   // R8 broadcast sets mark
    do_cmd(5'd9,  0, 0, 0, 5'b00000, 0);   // R8 bad parity keeps mark
    do_cmd(5'd9,  1, 1, 1, 5'b00000, 0);   // second broadcast
    do_cmd(5'd12, 1, 0, 0, 5'b01010, 1);   // R8 bit 4 set here
    do_cmd(5'd12, 1, 0, 0, 5'b01010, 0);   // R8 bit 4 cleared
    do_cmd(5'd21, 1, 0, 1, 5'b10000, 4);   // R10 hold with changes

    // Random mix
    for (int n = 0; n < 300; n++) begin
      do_cmd($urandom_range(0, 31), $urandom_range(0, 7) != 0,
             $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 31), $urandom_range(0, 3));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule